// File: doc/BRIEF.md
# Next-Line Prefetching Direct-Mapped Read Cache

This block is a small read-only data cache that sits between a processor load port and a line-wide main-memory fill interface. It holds 2 KB as 128 direct-mapped lines of 16 bytes. Every accepted load returns one byte, either from the cache or, on a miss, straight from the returning fill. Whole lines are always filled; a line is never partly valid.

Next to the demand path sits a sequential prefetcher. It looks exactly one line ahead. Whenever a load touches line `a`, whether it hits or misses, line `a+1` is queued for fetching unless it is already resident. The queued prefetch goes to memory only when no load is waiting. A later load replaces any prefetch that has not yet been issued. Only one memory fill is in flight at any time. Two counters expose the number of demand misses and the number of prefetch fills, so the memory traffic and the miss ratio can be measured from outside.

The controller is a four-state machine. ST_IDLE accepts a load (going to ST_LOOKUP), or, with no load present and a prefetch queued, issues that prefetch (going to ST_PF_WAIT). ST_LOOKUP answers a hit and returns to ST_IDLE, or starts a demand fill and moves to ST_DEMAND_WAIT. ST_DEMAND_WAIT returns the byte and goes back to ST_IDLE when the fill arrives. ST_PF_WAIT installs the prefetched line and goes back to ST_IDLE when the fill arrives.

Top module: `obl_cache`

## Requirements
- R1: An address is split into byte offset `addr[3:0]`, line index `addr[10:4]` (128 lines) and tag `addr[15:11]`. The line address sent to memory is `addr[15:4]`. Two lines with the same index but different tags cannot be resident together.
- R2: After reset, every line is invalid, `cpu_ready` is 1, `cpu_rvalid` and `mem_req` are 0, and both counters are 0.
- R3: A hit returns the addressed byte with `cpu_rvalid` high in the second cycle after the cycle in which the load was accepted (accepted means `cpu_req` and `cpu_ready` are both high at a clock edge). A hit issues no memory request, and each load produces exactly one single-cycle `cpu_rvalid` pulse.
- R4: A miss requests exactly one line fill at `mem_addr = addr[15:4]`. The byte is returned from the fill data in the cycle after `mem_valid`, so the miss latency is longer than the hit latency.
- R5: Every load to line `a`, hit or miss, queues a prefetch of line `a+1`, taken modulo 2^12 so that the line after 0xFFF is 0x000. The prefetch is dropped if line `a+1` is already resident with a matching tag.
- R6: A load presented while a prefetch is queued is served first. A load that arrives before the queued prefetch has been issued replaces it, and the replaced prefetch is never fetched.
- R7: At most one fill is outstanding. `mem_req` stays high with a stable `mem_addr` until `mem_valid`, and `cpu_ready` is low while a fill is outstanding.
- R8: A prefetched line overwrites whatever line occupies its index. A later load to the evicted line misses.
- R9: `miss_count` increments once for each demand fill and `prefetch_count` once for each prefetch fill. Every memory request is counted in exactly one of them.
- R10: A fill installs the whole line. Byte `k` of the line is `mem_data[8k+7:8k]`, and all 16 bytes of a filled line hit afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Load request |
| cpu_addr | input | ADDR_W (16) | Byte address of the load |
| cpu_ready | output | 1 | The cache can accept a load this cycle |
| cpu_rvalid | output | 1 | Load data valid (one-cycle pulse) |
| cpu_rdata | output | 8 | Loaded byte |
| mem_req | output | 1 | Line fill request, held until `mem_valid` |
| mem_addr | output | ADDR_W-4 (12) | Line address of the requested fill |
| mem_valid | input | 1 | Fill data valid (one cycle) |
| mem_data | input | 128 | Fill data, byte k in bits [8k+7:8k] |
| miss_count | output | CNT_W (32) | Number of demand fills |
| prefetch_count | output | CNT_W (32) | Number of prefetch fills |

## Verification
Directed sequences separate the cases that the prefetch rule tells apart. One pair of loads leaves an idle cycle, so a queued prefetch turns the next load into a hit. A load issued back to back replaces the queued prefetch, so a later load to the dropped line misses. A load whose successor is already resident must produce no fill. A prefetch that lands on an index shared with a different tag evicts the older line. The last line of the address space wraps its prefetch to line 0. Constrained random loads over a region with index conflicts, using random idle gaps and random memory latency, are then compared against a bench model of line residency and of the prefetch queue. The comparison covers returned data, hit latency and both counters.

// File: rtl/obl_pkg.sv
package obl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_LOOKUP      = 2'd1,
        ST_DEMAND_WAIT = 2'd2,
        ST_PF_WAIT     = 2'd3
    } obl_state_e;

endpackage

// File: rtl/obl_tag_store.sv
module obl_tag_store #(
    parameter int NUM_LINES = 128,
    parameter int IDX_W     = 7,
    parameter int TAG_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [TAG_W-1:0] a_tag,
    output logic             a_hit,
    input  logic [IDX_W-1:0] b_idx,
    input  logic [TAG_W-1:0] b_tag,
    output logic             b_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    // Demand port and next-line port
    always_comb begin
        a_hit = valid_q[a_idx] && (tag_q[a_idx] == a_tag);
        b_hit = valid_q[b_idx] && (tag_q[b_idx] == b_tag);
    end

    // R10: a written line is resident with its tag from the next cycle on
    p_fill_resident_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag))));

endmodule

// File: rtl/obl_line_store.sv
module obl_line_store #(
    parameter int NUM_LINES  = 128,
    parameter int IDX_W      = 7,
    parameter int LINE_BYTES = 16,
    parameter int OFF_W      = 4,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int BSEL_W    = OFF_W + 3
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [7:0]        rd_byte,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);

    logic [LINE_W-1:0] line_q [NUM_LINES];
    logic [LINE_W-1:0] rd_line;
    logic [BSEL_W-1:0] bit_pos;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx] <= wr_line;
        end
    end

    always_comb begin
        rd_line = line_q[rd_idx];
        bit_pos = {rd_off, 3'b000};
        rd_byte = rd_line[bit_pos +: 8];
    end

endmodule

// File: rtl/obl_ctrl.sv
module obl_ctrl
    import obl_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int OFF_W   = 4,
    parameter int IDX_W   = 7,
    parameter int LINE_W  = 128,
    parameter int CNT_W   = 32,
    localparam int LADDR_W = ADDR_W - OFF_W,
    localparam int TAG_W   = LADDR_W - IDX_W,
    localparam int BSEL_W  = OFF_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic [ADDR_W-1:0]  cpu_addr,
    output logic               cpu_ready,
    output logic               cpu_rvalid,
    output logic [7:0]         cpu_rdata,
    output logic               mem_req,
    output logic [LADDR_W-1:0] mem_addr,
    input  logic               mem_valid,
    input  logic [LINE_W-1:0]  mem_data,
    output logic [IDX_W-1:0]   a_idx,
    output logic [TAG_W-1:0]   a_tag,
    input  logic               a_hit,
    output logic [IDX_W-1:0]   b_idx,
    output logic [TAG_W-1:0]   b_tag,
    input  logic               b_hit,
    output logic [OFF_W-1:0]   rd_off,
    input  logic [7:0]         rd_byte,
    output logic               fill_we,
    output logic [IDX_W-1:0]   fill_idx,
    output logic [TAG_W-1:0]   fill_tag,
    output logic [CNT_W-1:0]   miss_count,
    output logic [CNT_W-1:0]   prefetch_count
);

    obl_state_e state_q, state_d;

    logic [LADDR_W-1:0] req_line_q;
    logic [OFF_W-1:0]   req_off_q;
    logic [LADDR_W-1:0] next_line;
    logic [LADDR_W-1:0] fill_line_q;
    logic               pf_queued_q;
    logic [LADDR_W-1:0] pf_line_q;
    logic               rvalid_q;
    logic [7:0]         rdata_q;
    logic [CNT_W-1:0]   miss_cnt_q;
    logic [CNT_W-1:0]   pf_cnt_q;
    logic [BSEL_W-1:0]  fill_bit_pos;

    assign next_line = req_line_q + LADDR_W'(1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    state_d = ST_LOOKUP;
                end else if (pf_queued_q) begin
                    state_d = ST_PF_WAIT;
                end
            end
            ST_LOOKUP: begin
                state_d = a_hit ? ST_IDLE : ST_DEMAND_WAIT;
            end
            ST_DEMAND_WAIT: begin
                if (mem_valid) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PF_WAIT: begin
                if (mem_valid) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        unique case (state_q)
            ST_IDLE:        cpu_ready = 1'b1;
            ST_LOOKUP:      cpu_ready = 1'b0;
            ST_DEMAND_WAIT: mem_req   = 1'b1;
            ST_PF_WAIT:     mem_req   = 1'b1;
            default:        cpu_ready = 1'b0;
        endcase
        fill_we = mem_req && mem_valid;
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_line_q  <= '0;
            req_off_q   <= '0;
            fill_line_q <= '0;
            pf_queued_q <= 1'b0;
            pf_line_q   <= '0;
            rvalid_q    <= 1'b0;
            rdata_q     <= '0;
            miss_cnt_q  <= '0;
            pf_cnt_q    <= '0;
        end else begin
            rvalid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        req_line_q <= cpu_addr[ADDR_W-1:OFF_W];
                        req_off_q  <= cpu_addr[OFF_W-1:0];
                    end else if (pf_queued_q) begin
                        fill_line_q <= pf_line_q;
                        pf_queued_q <= 1'b0;
                        pf_cnt_q    <= pf_cnt_q + CNT_W'(1);
                    end
                end
                ST_LOOKUP: begin
                    // Any access replaces the queue with its own successor
                    pf_queued_q <= !b_hit;
                    pf_line_q   <= next_line;
                    if (a_hit) begin
                        rvalid_q <= 1'b1;
                        rdata_q  <= rd_byte;
                    end else begin
                        fill_line_q <= req_line_q;
                        miss_cnt_q  <= miss_cnt_q + CNT_W'(1);
                    end
                end
                ST_DEMAND_WAIT: begin
                    if (mem_valid) begin
                        rvalid_q <= 1'b1;
                        rdata_q  <= mem_data[fill_bit_pos +: 8];
                    end
                end
                ST_PF_WAIT: begin
                    rvalid_q <= 1'b0;
                end
                default: rvalid_q <= 1'b0;
            endcase
        end
    end

    always_comb begin
        fill_bit_pos   = {req_off_q, 3'b000};
        a_idx          = req_line_q[IDX_W-1:0];
        a_tag          = req_line_q[LADDR_W-1:IDX_W];
        b_idx          = next_line[IDX_W-1:0];
        b_tag          = next_line[LADDR_W-1:IDX_W];
        rd_off         = req_off_q;
        fill_idx       = fill_line_q[IDX_W-1:0];
        fill_tag       = fill_line_q[LADDR_W-1:IDX_W];
        mem_addr       = fill_line_q;
        cpu_rvalid     = rvalid_q;
        cpu_rdata      = rdata_q;
        miss_count     = miss_cnt_q;
        prefetch_count = pf_cnt_q;
    end

    p_fill_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid);

    p_fetch_counted_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> (((miss_cnt_q - $past(miss_cnt_q)) + (pf_cnt_q - $past(pf_cnt_q))) == CNT_W'(1)));

    p_prefetch_yields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_cnt_q != $past(pf_cnt_q)) |-> !$past(cpu_req));

endmodule

// File: rtl/obl_cache.sv
module obl_cache #(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 128,
    parameter int CNT_W      = 32,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int LADDR_W   = ADDR_W - OFF_W,
    localparam int TAG_W     = LADDR_W - IDX_W,
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic [ADDR_W-1:0]  cpu_addr,
    output logic               cpu_ready,
    output logic               cpu_rvalid,
    output logic [7:0]         cpu_rdata,
    output logic               mem_req,
    output logic [LADDR_W-1:0] mem_addr,
    input  logic               mem_valid,
    input  logic [LINE_W-1:0]  mem_data,
    output logic [CNT_W-1:0]   miss_count,
    output logic [CNT_W-1:0]   prefetch_count
);

    logic [IDX_W-1:0] a_idx, b_idx, fill_idx;
    logic [TAG_W-1:0] a_tag, b_tag, fill_tag;
    logic             a_hit, b_hit, fill_we;
    logic [OFF_W-1:0] rd_off;
    logic [7:0]       rd_byte;

    obl_ctrl #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .LINE_W (LINE_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req        (cpu_req),
        .cpu_addr       (cpu_addr),
        .cpu_ready      (cpu_ready),
        .cpu_rvalid     (cpu_rvalid),
        .cpu_rdata      (cpu_rdata),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr),
        .mem_valid      (mem_valid),
        .mem_data       (mem_data),
        .a_idx          (a_idx),
        .a_tag          (a_tag),
        .a_hit          (a_hit),
        .b_idx          (b_idx),
        .b_tag          (b_tag),
        .b_hit          (b_hit),
        .rd_off         (rd_off),
        .rd_byte        (rd_byte),
        .fill_we        (fill_we),
        .fill_idx       (fill_idx),
        .fill_tag       (fill_tag),
        .miss_count     (miss_count),
        .prefetch_count (prefetch_count)
    );

    obl_tag_store #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W)
    ) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_idx  (a_idx),
        .a_tag  (a_tag),
        .a_hit  (a_hit),
        .b_idx  (b_idx),
        .b_tag  (b_tag),
        .b_hit  (b_hit),
        .wr_en  (fill_we),
        .wr_idx (fill_idx),
        .wr_tag (fill_tag)
    );

    obl_line_store #(
        .NUM_LINES  (NUM_LINES),
        .IDX_W      (IDX_W),
        .LINE_BYTES (LINE_BYTES),
        .OFF_W      (OFF_W)
    ) u_lines (
        .clk     (clk),
        .rd_idx  (a_idx),
        .rd_off  (rd_off),
        .rd_byte (rd_byte),
        .wr_en   (fill_we),
        .wr_idx  (fill_idx),
        .wr_line (mem_data)
    );

endmodule

// File: tb/test_obl_cache.sv
module test_obl_cache;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0;
    logic [15:0]  cpu_addr = '0;
    logic         cpu_ready;
    logic         cpu_rvalid;
    logic [7:0]   cpu_rdata;
    logic         mem_req;
    logic [11:0]  mem_addr;
    logic         mem_valid = 1'b0;
    logic [127:0] mem_data = '0;
    logic [31:0]  miss_count;
    logic [31:0]  prefetch_count;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    // memory-side log
    int          fetch_cnt = 0;
    logic [11:0] last_fetch = '0;

    // bench model of residency and prefetch queue
    bit          mv [128];
    logic [4:0]  mt [128];
    bit          pfq_v = 0;
    logic [11:0] pfq_line = '0;
    int          exp_miss = 0;
    int          exp_pf = 0;

    always #10 clk = ~clk;  // 50 MHz

    obl_cache i_obl_cache (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req        (cpu_req),
        .cpu_addr       (cpu_addr),
        .cpu_ready      (cpu_ready),
        .cpu_rvalid     (cpu_rvalid),
        .cpu_rdata      (cpu_rdata),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr),
        .mem_valid      (mem_valid),
        .mem_data       (mem_data),
        .miss_count     (miss_count),
        .prefetch_count (prefetch_count)
    );

    function automatic logic [7:0] exp_byte(input logic [15:0] a);
        return a[7:0] ^ 8'(a[15:8] * 8'd29) ^ 8'hA5;
    endfunction

    function automatic logic [127:0] line_of(input logic [11:0] l);
        logic [127:0] d;
        for (int k = 0; k < 16; k++) d[k*8 +: 8] = exp_byte({l, 4'(k)});
        return d;
    endfunction

    function automatic bit present(input logic [11:0] l);
        return mv[l[6:0]] && (mt[l[6:0]] == l[11:7]);
    endfunction

    function automatic void install(input logic [11:0] l);
        mv[l[6:0]] = 1'b1;
        mt[l[6:0]] = l[11:7];
    endfunction

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                finish_run();
            end
        end
    end

    // memory model: random latency, one line per request; checks R7
    initial begin
        bit          served = 0;
        bit          holding = 0;
        logic [11:0] held = '0;
        int          wait_left = 0;
        forever begin
            @(negedge clk);
            mem_valid = 1'b0;
            if (!rst_n) begin
                served = 0;
                holding = 0;
            end else if (mem_req) begin
                if (!served) begin
                    if (!holding) begin
                        holding = 1;
                        held = mem_addr;
                        wait_left = int'($urandom_range(0, 3));
                        fetch_cnt++;
                        last_fetch = mem_addr;
                    end else if (mem_addr != held) begin
                        check(0, "R7 addr held", mem_addr, held);
                    end
                    if (cpu_ready) check(0, "R7 ready low during fill", cpu_ready, 0);
                    if (wait_left == 0) begin
                        mem_valid = 1'b1;
                        mem_data = line_of(held);
                        served = 1;
                        holding = 0;
                    end else begin
                        wait_left--;
                    end
                end
            end else begin
                served = 0;
            end
        end
    end

    task automatic do_access(input logic [15:0] a, input int gap, output int lat);
        logic [11:0] la;
        logic [11:0] nl;
        bit          hit;
        int          guard;
        la = a[15:4];
        nl = la + 12'd1;
        if (gap > 0) begin
            if (pfq_v) begin
                install(pfq_line);
                exp_pf++;
                pfq_v = 0;
            end
            repeat (gap) @(negedge clk);
            guard = 0;
            while (!cpu_ready && guard < 200) begin
                @(negedge clk);
                guard++;
            end
        end
        hit = present(la);
        if (!hit) begin
            install(la);
            exp_miss++;
        end
        if (present(nl)) pfq_v = 0;
        else begin
            pfq_v = 1;
            pfq_line = nl;
        end
        cpu_req = 1'b1;
        cpu_addr = a;
        @(negedge clk);
        cpu_req = 1'b0;
        lat = 1;
        while (!cpu_rvalid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(cpu_rdata == exp_byte(a), hit ? "R3 hit data" : "R4 miss data", cpu_rdata, exp_byte(a));
        if (hit) begin
            check(lat == 2, "R3 hit latency", lat, 2);
        end else begin
            check(lat > 2, "R4 miss latency", lat, 3);
            check(last_fetch == la, "R4 fill address", last_fetch, la);
        end
        check(miss_count == 32'(exp_miss), "R9 miss count", miss_count, exp_miss);
        check(prefetch_count == 32'(exp_pf), "R9 prefetch count", prefetch_count, exp_pf);
        check(fetch_cnt == exp_miss + exp_pf, "R7 one fill per counted fetch", fetch_cnt, exp_miss + exp_pf);
    endtask

    initial begin
        int lat;
        int pf_snap;
        int fetch_snap;
        void'($urandom(32'd20240607));
        for (int i = 0; i < 128; i++) begin
            mv[i] = 0;
            mt[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check(cpu_ready == 1'b1, "R2 ready", cpu_ready, 1);
        check(cpu_rvalid == 1'b0, "R2 rvalid", cpu_rvalid, 0);
        check(mem_req == 1'b0, "R2 mem_req", mem_req, 0);
        check(miss_count == 0 && prefetch_count == 0, "R2 counters", miss_count + prefetch_count, 0);

        // R2/R4: first access misses into empty cache, fill at addr[15:4]
        do_access(16'h0123, 0, lat);
        check(last_fetch == 12'h012, "R1 line address", last_fetch, 12'h012);
        // R5: idle gap lets prefetch of 0x013 run, so this hits
        do_access(16'h0135, 1, lat);
        check(lat == 2, "R5 prefetched line hits", lat, 2);
        check(last_fetch == 12'h013, "R5 prefetch address", last_fetch, 12'h013);
        // R10: far end of prefetched line
        do_access(16'h013F, 0, lat);
        check(lat == 2, "R10 whole line present", lat, 2);
        do_access(16'h0140, 1, lat);
        // R5 drop: successor 0x014 resident, no fill issued during gap
        do_access(16'h0130, 0, lat);
        pf_snap = int'(prefetch_count);
        fetch_snap = fetch_cnt;
        do_access(16'h0131, 3, lat);
        check(int'(prefetch_count) == pf_snap, "R5 resident successor dropped", prefetch_count, pf_snap);
        check(fetch_cnt == fetch_snap, "R5 no fetch when dropped", fetch_cnt, fetch_snap);

        // R6: back-to-back demand replaces queued prefetch
        do_access(16'h0400, 0, lat);
        do_access(16'h0800, 0, lat);
        check(last_fetch == 12'h080, "R6 demand before prefetch", last_fetch, 12'h080);
        do_access(16'h0810, 1, lat);
        check(last_fetch == 12'h081, "R6 surviving prefetch", last_fetch, 12'h081);
        do_access(16'h0410, 0, lat);
        check(lat > 2, "R6 replaced prefetch never fetched", lat, 3);

        // R8/R1: prefetch of 0x101 evicts 0x081 from index 1
        do_access(16'h1000, 0, lat);
        do_access(16'h2222, 1, lat);
        do_access(16'h0815, 0, lat);
        check(lat > 2, "R8 evicted line misses", lat, 3);
        check(last_fetch == 12'h081, "R1 same index other tag refetched", last_fetch, 12'h081);

        // R5 wrap: successor of 0xFFF is 0x000
        do_access(16'hFFF8, 0, lat);
        do_access(16'h0003, 1, lat);
        check(lat == 2, "R5 wrap prefetch hits", lat, 2);
        check(last_fetch == 12'h000, "R5 wrap address", last_fetch, 12'h000);

        // constrained random
        for (int n = 0; n < 400; n++) begin
            logic [15:0] ra;
            ra = 16'($urandom_range(0, 16'h03FF)) | (16'($urandom_range(0, 1)) << 11);
            do_access(ra, int'($urandom_range(0, 2)), lat);
        end

        finish_run();
    end

endmodule